// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Accessor

This block gives a local requester access to byte ring buffers that live in another processor's memory. Each buffer has a three-byte header just below its base address: the index mask, the producer index and the consumer index. The block can reach that memory only through a bus-master port that does single-byte reads and writes. Before it touches the port it must acquire that memory through a request/grant handshake, and it gives the memory back once the operation is over.

Four descriptor slots each keep a base address and local copies of the mask and both indices. The requester gives a command with an opcode, a slot selector, a base address (used only when a slot is set up) and a data byte. `busy` stays high while the command runs. A one-cycle `done` pulse ends the command and carries the result flag and the data byte. Reads and writes toward the shared memory are each held until the memory side answers with `mem_ready`.

Top module: `rb_ring_port`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `mem_valid` are all low, and all four slots are unconfigured (base address zero).
- R2: Opcode 0 (set up) stores `cmd_base` in the selected slot. It then reads base−3, base−2 and base−1 in that order, into the local mask, producer index and consumer index. It completes with flag 0.
- R3: Opcode 1 (empty test) reads base−2 once. Its flag is 1 exactly when that fresh producer index equals the local consumer index.
- R4: Opcode 2 (full test) reads base−1 once. Its flag is 1 exactly when (local producer index + 1) AND mask equals that fresh consumer index.
- R5: Opcode 3 (take) returns the byte at base + consumer index on `rsp_data`. It sets the consumer index to (index + 1) AND mask, writes the new value to base−1, and completes with flag 0. The index wraps through zero.
- R6: Opcode 4 (give) writes `cmd_wdata` at base + producer index. It sets the producer index to (index + 1) AND mask, writes the new value to base−2, and completes with flag 0. The index wraps through zero.
- R7: A take on an empty buffer, or a give on a full buffer, does not complete. It releases the memory and asks for it again, re-checking the fresh index each time. It completes once the other side has moved that index.
- R8: Opcode 5 (discard) stores `cmd_base` and reads the mask and producer index. It then writes the producer index to base−1 and sets both local indices to it, so a following empty test reports 1.
- R9: An empty test, full test, take or give on an unconfigured slot completes at once with flag 1 and no bus request. Opcodes 6 and 7 do the same. Set up or discard with `cmd_base` zero makes the slot unconfigured, also without a bus request.
- R10: `bus_req` is held from the start of an operation until `bus_gnt` is seen. Memory accesses happen only while both are high. `bus_req` is low when `done` pulses, and `done` waits until `bus_gnt` has dropped.
- R11: The slots are independent: commands on one slot leave another slot's indices and pending data unchanged.
- R12: `busy` is high from command accept until the command completes, and `done` comes as `busy` falls. A command presented while `busy` is high is ignored.
- R13: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present (taken when not busy) |
| cmd_op | input | 3 | Opcode (0 set up, 1 empty, 2 full, 3 take, 4 give, 5 discard) |
| cmd_slot | input | 2 | Descriptor slot selector |
| cmd_base | input | AW | Buffer base address for set up and discard |
| cmd_wdata | input | 8 | Byte for a give |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_flag | output | 1 | Test result, or 1 for a refused command |
| rsp_data | output | 8 | Byte returned by a take |
| bus_req | output | 1 | Request for the shared memory |
| bus_gnt | input | 1 | Grant of the shared memory |
| mem_valid | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 8 | Read data |

## Verification
The bench fills a buffer whose mask is 7 until it is full, then drains it. Both indices wrap through zero. A design that drops the mask or compares against the wrong index either reports full one byte early or late, or writes past the ring. A take on an empty buffer is held while the bench updates the header from outside. A design that does not give the memory back between polls stays blocked, and a design that trusts its stale local copy returns a wrong byte. Commands on unconfigured slots must not raise a bus request. A stray command sent while the block is busy must leave the other slot's data in place. The memory model stalls every other access, so a design that moves its address before `mem_ready` would hit the wrong bytes.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [2:0] {
        OP_SETUP   = 3'd0,
        OP_EMPTY   = 3'd1,
        OP_FULL    = 3'd2,
        OP_TAKE    = 3'd3,
        OP_GIVE    = 3'd4,
        OP_DISCARD = 3'd5
    } rb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_ACC,
        ST_REL
    } rb_st_e;

    localparam int HDR_MASK_OFS = 3;
    localparam int HDR_PROD_OFS = 2;
    localparam int HDR_CONS_OFS = 1;

endpackage

// File: rtl/rb_slot_table.sv
module rb_slot_table #(
    parameter int AW    = 16,
    parameter int NSLOT = 4,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [AW-1:0] wr_base,
    input  logic [7:0]    wr_mask,
    input  logic [7:0]    wr_prod,
    input  logic [7:0]    wr_cons,
    input  logic [SW-1:0] rd_slot,
    output logic [AW-1:0] rd_base,
    output logic [7:0]    rd_mask,
    output logic [7:0]    rd_prod,
    output logic [7:0]    rd_cons
);

    logic [AW-1:0] base_q [NSLOT];
    logic [7:0]    mask_q [NSLOT];
    logic [7:0]    prod_q [NSLOT];
    logic [7:0]    cons_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == SW'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[s] <= '0;
                mask_q[s] <= '0;
                prod_q[s] <= '0;
                cons_q[s] <= '0;
            end else if (hit) begin
                base_q[s] <= wr_base;
                mask_q[s] <= wr_mask;
                prod_q[s] <= wr_prod;
                cons_q[s] <= wr_cons;
            end
        end
    end

    assign rd_base = base_q[rd_slot];
    assign rd_mask = mask_q[rd_slot];
    assign rd_prod = prod_q[rd_slot];
    assign rd_cons = cons_q[rd_slot];

endmodule

// File: rtl/rb_addr_gen.sv
module rb_addr_gen
    import rb_pkg::*;
#(
    parameter int AW = 16
) (
    input  rb_op_e        op,
    input  logic [1:0]    step,
    input  logic [AW-1:0] base,
    input  logic [7:0]    prod,
    input  logic [7:0]    cons,
    input  logic [7:0]    wdata,
    output logic [AW-1:0] addr,
    output logic          we,
    output logic [7:0]    data
);

    logic [AW-1:0] a_mask, a_prod, a_cons, a_slot_p, a_slot_c;

    always_comb begin
        a_mask   = base - AW'(HDR_MASK_OFS);
        a_prod   = base - AW'(HDR_PROD_OFS);
        a_cons   = base - AW'(HDR_CONS_OFS);
        a_slot_p = base + AW'(prod);
        a_slot_c = base + AW'(cons);
        addr     = base;
        we       = 1'b0;
        data     = 8'h00;
        unique case (op)
            OP_SETUP: begin
                addr = (step == 2'd0) ? a_mask : (step == 2'd1) ? a_prod : a_cons;
            end
            OP_DISCARD: begin
                addr = (step == 2'd0) ? a_mask : (step == 2'd1) ? a_prod : a_cons;
                we   = (step == 2'd2);
                data = cons;
            end
            OP_EMPTY: addr = a_prod;
            OP_FULL:  addr = a_cons;
            OP_TAKE: begin
                addr = (step == 2'd0) ? a_prod : (step == 2'd1) ? a_slot_c : a_cons;
                we   = (step == 2'd2);
                data = cons;
            end
            OP_GIVE: begin
                addr = (step == 2'd0) ? a_cons : (step == 2'd1) ? a_slot_p : a_prod;
                we   = (step != 2'd0);
                data = (step == 2'd1) ? wdata : prod;
            end
            default: addr = base;
        endcase
    end

endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
    import rb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSLOT = 4,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_slot,
    input  logic [AW-1:0] cmd_base,
    input  logic [7:0]    cmd_wdata,
    input  logic [AW-1:0] tbl_base,
    input  logic [7:0]    tbl_mask,
    input  logic [7:0]    tbl_prod,
    input  logic [7:0]    tbl_cons,
    output logic          tbl_we,
    output logic [SW-1:0] tbl_slot,
    output logic [AW-1:0] upd_base,
    output logic [7:0]    upd_mask,
    output logic [7:0]    upd_prod,
    output logic [7:0]    upd_cons,
    input  logic          bus_gnt,
    input  logic          mem_ready,
    input  logic [7:0]    mem_rdata,
    output logic          bus_req,
    output logic          acc_valid,
    output rb_op_e        cur_op,
    output logic [1:0]    cur_step,
    output logic [AW-1:0] cur_base,
    output logic [7:0]    cur_prod,
    output logic [7:0]    cur_cons,
    output logic [7:0]    cur_wdata,
    output logic          busy,
    output logic          done,
    output logic          rsp_flag,
    output logic [7:0]    rsp_data
);

    typedef struct packed {
        rb_st_e        st;
        rb_op_e        op;
        logic [SW-1:0] slot;
        logic [7:0]    wdata;
        logic [AW-1:0] base;
        logic [7:0]    mask;
        logic [7:0]    prod;
        logic [7:0]    cons;
        logic [1:0]    step;
        logic          retry;
        logic          flag;
        logic [7:0]    rdata;
        logic          done;
    } ctrl_t;

    ctrl_t s_q, s_d;

    logic          is_setup, op_known, blocked;
    logic [1:0]    last_step;
    logic [7:0]    prod_inc, cons_inc;
    logic [AW-1:0] eff_base;
    rb_op_e        new_op;

    always_comb begin
        s_d       = s_q;
        tbl_we    = 1'b0;
        blocked   = 1'b0;
        new_op    = rb_op_e'(cmd_op);
        is_setup  = (new_op == OP_SETUP) || (new_op == OP_DISCARD);
        op_known  = (cmd_op <= 3'd5);
        eff_base  = is_setup ? cmd_base : tbl_base;
        prod_inc  = (s_q.prod + 8'd1) & s_q.mask;
        cons_inc  = (s_q.cons + 8'd1) & s_q.mask;
        last_step = ((s_q.op == OP_EMPTY) || (s_q.op == OP_FULL)) ? 2'd0 : 2'd2;

        unique case (s_q.st)
            ST_IDLE: begin
                s_d.done = 1'b0;
                if (cmd_valid) begin
                    s_d.op    = new_op;
                    s_d.slot  = cmd_slot;
                    s_d.wdata = cmd_wdata;
                    s_d.base  = eff_base;
                    s_d.mask  = is_setup ? 8'h00 : tbl_mask;
                    s_d.prod  = is_setup ? 8'h00 : tbl_prod;
                    s_d.cons  = is_setup ? 8'h00 : tbl_cons;
                    s_d.step  = 2'd0;
                    s_d.retry = 1'b0;
                    s_d.flag  = 1'b0;
                    if (!op_known || (eff_base == '0)) begin
                        s_d.done = 1'b1;
                        s_d.flag = !(is_setup && op_known);
                        tbl_we   = is_setup && op_known;
                    end else begin
                        s_d.st = ST_ACQ;
                    end
                end
            end
            ST_ACQ: begin
                if (bus_gnt) s_d.st = ST_ACC;
            end
            ST_ACC: begin
                if (mem_ready) begin
                    unique case (s_q.op)
                        OP_SETUP: begin
                            if (s_q.step == 2'd0) s_d.mask = mem_rdata;
                            if (s_q.step == 2'd1) s_d.prod = mem_rdata;
                            if (s_q.step == 2'd2) s_d.cons = mem_rdata;
                        end
                        OP_DISCARD: begin
                            if (s_q.step == 2'd0) s_d.mask = mem_rdata;
                            if (s_q.step == 2'd1) begin
                                s_d.prod = mem_rdata;
                                s_d.cons = mem_rdata;
                            end
                        end
                        OP_EMPTY: s_d.flag = (mem_rdata == s_q.cons);
                        OP_FULL:  s_d.flag = (prod_inc == mem_rdata);
                        OP_TAKE: begin
                            if (s_q.step == 2'd0) blocked = (mem_rdata == s_q.cons);
                            if (s_q.step == 2'd1) begin
                                s_d.rdata = mem_rdata;
                                s_d.cons  = cons_inc;
                            end
                        end
                        OP_GIVE: begin
                            if (s_q.step == 2'd0) blocked = (prod_inc == mem_rdata);
                            if (s_q.step == 2'd1) s_d.prod = prod_inc;
                        end
                        default: ;
                    endcase
                    if (blocked) begin
                        s_d.st    = ST_REL;
                        s_d.retry = 1'b1;
                    end else if (s_q.step == last_step) begin
                        s_d.st    = ST_REL;
                        s_d.retry = 1'b0;
                    end else begin
                        s_d.step = s_q.step + 2'd1;
                    end
                end
            end
            ST_REL: begin
                if (!bus_gnt) begin
                    s_d.step = 2'd0;
                    if (s_q.retry) begin
                        s_d.st    = ST_ACQ;
                        s_d.retry = 1'b0;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        tbl_we   = 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: OP_SETUP, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tbl_slot  = s_d.slot;
    assign upd_base  = s_d.base;
    assign upd_mask  = s_d.mask;
    assign upd_prod  = s_d.prod;
    assign upd_cons  = s_d.cons;

    assign bus_req   = (s_q.st == ST_ACQ) || (s_q.st == ST_ACC);
    assign acc_valid = (s_q.st == ST_ACC);
    assign cur_op    = s_q.op;
    assign cur_step  = s_q.step;
    assign cur_base  = s_q.base;
    assign cur_prod  = s_q.prod;
    assign cur_cons  = s_q.cons;
    assign cur_wdata = s_q.wdata;
    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.done;
    assign rsp_flag  = s_q.flag;
    assign rsp_data  = s_q.rdata;

endmodule

// File: rtl/rb_ring_port.sv
module rb_ring_port
    import rb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSLOT = 4,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_slot,
    input  logic [AW-1:0] cmd_base,
    input  logic [7:0]    cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic          rsp_flag,
    output logic [7:0]    rsp_data,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ready,
    input  logic [7:0]    mem_rdata
);

    logic          tbl_we;
    logic [SW-1:0] tbl_slot;
    logic [AW-1:0] upd_base, tbl_base, cur_base;
    logic [7:0]    upd_mask, upd_prod, upd_cons;
    logic [7:0]    tbl_mask, tbl_prod, tbl_cons;
    logic [7:0]    cur_prod, cur_cons, cur_wdata;
    logic [1:0]    cur_step;
    rb_op_e        cur_op;

    rb_slot_table #(.AW(AW), .NSLOT(NSLOT)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_slot (tbl_slot),
        .wr_base (upd_base),
        .wr_mask (upd_mask),
        .wr_prod (upd_prod),
        .wr_cons (upd_cons),
        .rd_slot (cmd_slot),
        .rd_base (tbl_base),
        .rd_mask (tbl_mask),
        .rd_prod (tbl_prod),
        .rd_cons (tbl_cons)
    );

    rb_ctrl #(.AW(AW), .NSLOT(NSLOT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_slot  (cmd_slot),
        .cmd_base  (cmd_base),
        .cmd_wdata (cmd_wdata),
        .tbl_base  (tbl_base),
        .tbl_mask  (tbl_mask),
        .tbl_prod  (tbl_prod),
        .tbl_cons  (tbl_cons),
        .tbl_we    (tbl_we),
        .tbl_slot  (tbl_slot),
        .upd_base  (upd_base),
        .upd_mask  (upd_mask),
        .upd_prod  (upd_prod),
        .upd_cons  (upd_cons),
        .bus_gnt   (bus_gnt),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .acc_valid (mem_valid),
        .cur_op    (cur_op),
        .cur_step  (cur_step),
        .cur_base  (cur_base),
        .cur_prod  (cur_prod),
        .cur_cons  (cur_cons),
        .cur_wdata (cur_wdata),
        .busy      (busy),
        .done      (done),
        .rsp_flag  (rsp_flag),
        .rsp_data  (rsp_data)
    );

    rb_addr_gen #(.AW(AW)) u_addr (
        .op    (cur_op),
        .step  (cur_step),
        .base  (cur_base),
        .prod  (cur_prod),
        .cons  (cur_cons),
        .wdata (cur_wdata),
        .addr  (mem_addr),
        .we    (mem_we),
        .data  (mem_wdata)
    );

endmodule

// File: rtl/rb_ring_port_chk.sv
module rb_ring_port_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata
);

    assert_access_in_tenure_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_req && bus_gnt));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_released_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    assert_access_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_ends_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind rb_ring_port rb_ring_port_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_rb_ring_port.sv
`timescale 1ns/1ps
module tb_rb_ring_port;

    localparam int AW = 16;
    localparam logic [2:0] C_SETUP = 3'd0, C_EMPTY = 3'd1, C_FULL = 3'd2,
                           C_TAKE = 3'd3, C_GIVE = 3'd4, C_DISCARD = 3'd5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [1:0]    cmd_slot = '0;
    logic [AW-1:0] cmd_base = '0;
    logic [7:0]    cmd_wdata = '0;
    logic          busy, done, rsp_flag, bus_req, mem_valid, mem_we, mem_ready;
    logic          bus_gnt, gnt_pipe, tick;
    logic [7:0]    rsp_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    rb_ring_port #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_slot(cmd_slot), .cmd_base(cmd_base), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rsp_flag(rsp_flag), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [4096];

    always @(posedge clk or negedge rst_n)
        if (!rst_n) tick <= 1'b0; else tick <= ~tick;
    assign mem_ready = mem_valid && tick;
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk)
        if (mem_valid && mem_ready && mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) begin
            gnt_pipe <= 1'b0;
            bus_gnt  <= 1'b0;
        end else begin
            gnt_pipe <= bus_req;
            bus_gnt  <= gnt_pipe && bus_req;
        end

    int            acc_total = 0, req_rises = 0, bad_tenure = 0, bad_hold = 0, stalls = 0;
    logic [AW-1:0] acc_log [64];
    logic          req_prev = 1'b0, stall_prev = 1'b0;
    logic [AW-1:0] addr_prev = '0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                acc_log[acc_total % 64] = mem_addr;
                acc_total++;
            end
            if (bus_req && !req_prev) req_rises++;
            if (mem_valid && !bus_gnt) bad_tenure++;
            if (stall_prev && (!mem_valid || mem_addr != addr_prev)) bad_hold++;
            if (mem_valid && !mem_ready) stalls++;
        end
        req_prev   <= bus_req;
        stall_prev <= mem_valid && !mem_ready;
        addr_prev  <= mem_addr;
    end

    int         tests = 0, fails = 0;
    logic       r_flag;
    logic [7:0] r_data;
    int         r_rises, r_acc0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] slot,
                       input logic [AW-1:0] base, input logic [7:0] wd);
        int rises0;
        @(negedge clk);
        rises0    = req_rises;
        r_acc0    = acc_total;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_slot  = slot;
        cmd_base  = base;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        r_flag  = rsp_flag;
        r_data  = rsp_data;
        r_rises = req_rises - rises0;
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            C_SETUP: return "R2";
            C_EMPTY: return "R3";
            C_FULL:  return "R4";
            C_TAKE:  return "R5";
            default: return "R6";
        endcase
    endfunction

    // {op, slot, base, wdata, expected flag, expected data}
    localparam int NV = 9;
    localparam logic [37:0] VEC [NV] = '{
        {C_SETUP, 2'd0, 16'h0100, 8'h00, 1'b0, 8'h00},
        {C_EMPTY, 2'd0, 16'h0000, 8'h00, 1'b1, 8'h00},
        {C_FULL,  2'd0, 16'h0000, 8'h00, 1'b0, 8'h00},
        {C_GIVE,  2'd0, 16'h0000, 8'h11, 1'b0, 8'h00},
        {C_GIVE,  2'd0, 16'h0000, 8'h22, 1'b0, 8'h00},
        {C_EMPTY, 2'd0, 16'h0000, 8'h00, 1'b0, 8'h00},
        {C_TAKE,  2'd0, 16'h0000, 8'h00, 1'b0, 8'h11},
        {C_TAKE,  2'd0, 16'h0000, 8'h00, 1'b0, 8'h22},
        {C_EMPTY, 2'd0, 16'h0000, 8'h00, 1'b1, 8'h00}
    };

    task automatic main_seq();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'h0FD] = 8'h07; mem[12'h0FE] = 8'h00; mem[12'h0FF] = 8'h00;
        mem[12'h1FD] = 8'h03; mem[12'h1FE] = 8'h00; mem[12'h1FF] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !bus_req && !mem_valid, "R1 outputs idle after reset",
              {busy, done, bus_req, mem_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [37:0] e;
            e = VEC[v];
            run(e[37:35], e[34:33], e[32:17], e[16:9]);
            check(r_flag == e[8], tag_of(e[37:35]), r_flag, e[8]);
            if (e[37:35] == C_TAKE) check(r_data == e[7:0], "R5 take data", r_data, e[7:0]);
        end

        // R2: header read order
        run(C_SETUP, 2'd0, 16'h0100, 8'h00);
        check((acc_total - r_acc0) == 3 && acc_log[r_acc0 % 64] == 16'h00FD &&
              acc_log[(r_acc0 + 1) % 64] == 16'h00FE && acc_log[(r_acc0 + 2) % 64] == 16'h00FF,
              "R2 header read order", acc_log[r_acc0 % 64], 16'h00FD);

        // R6 fill with wrap, R4 full
        for (int i = 0; i < 7; i++) run(C_GIVE, 2'd0, '0, 8'h40 + 8'(i));
        run(C_FULL, 2'd0, '0, 8'h00);
        check(r_flag == 1'b1, "R4 full after seven", r_flag, 1);
        check(mem[12'h0FE] == 8'h01, "R6 producer wrapped", mem[12'h0FE], 1);
        check(mem[12'h100] == 8'h46, "R6 byte at wrapped slot", mem[12'h100], 8'h46);

        // R5 drain with wrap
        for (int i = 0; i < 7; i++) begin
            run(C_TAKE, 2'd0, '0, 8'h00);
            check(r_data == 8'h40 + 8'(i), "R5 drain order", r_data, 8'h40 + i);
        end
        check(mem[12'h0FF] == 8'h01, "R5 consumer wrapped", mem[12'h0FF], 1);

        // R9 unconfigured slots
        run(C_EMPTY, 2'd2, '0, 8'h00);
        check(r_flag == 1'b1 && r_rises == 0, "R9 empty on unconfigured", {r_flag, 8'(r_rises)}, 9'h100);
        run(C_TAKE, 2'd3, '0, 8'h00);
        check(r_flag == 1'b1 && r_rises == 0, "R9 take on unconfigured", {r_flag, 8'(r_rises)}, 9'h100);

        // R11 pending data on slot 0 while slot 1 works
        run(C_GIVE, 2'd0, '0, 8'h77);
        run(C_SETUP, 2'd1, 16'h0200, 8'h00);

        // R7 blocked take, R12 stray command while busy
        fork
            run(C_TAKE, 2'd1, '0, 8'h00);
            begin
                repeat (20) @(negedge clk);
                check(busy == 1'b1, "R12 busy while blocked", busy, 1);
                cmd_valid = 1'b1; cmd_op = C_GIVE; cmd_slot = 2'd0; cmd_wdata = 8'h99;
                @(negedge clk);
                cmd_valid = 1'b0;
                repeat (60) @(negedge clk);
                mem[12'h200] = 8'h5A;
                mem[12'h1FE] = 8'h01;
            end
        join
        check(r_data == 8'h5A, "R7 blocked take data", r_data, 8'h5A);
        check(r_rises >= 2, "R7 bus released between polls", r_rises, 2);
        check(mem[12'h1FF] == 8'h01, "R7 consumer written", mem[12'h1FF], 1);

        run(C_TAKE, 2'd0, '0, 8'h00);
        check(r_data == 8'h77, "R11 slot 0 data kept", r_data, 8'h77);
        run(C_EMPTY, 2'd0, '0, 8'h00);
        check(r_flag == 1'b1, "R12 stray give ignored", r_flag, 1);

        // R8 discard
        mem[12'h1FE] = 8'h03;
        run(C_DISCARD, 2'd1, 16'h0200, 8'h00);
        check(mem[12'h1FF] == 8'h03, "R8 consumer set to producer", mem[12'h1FF], 3);
        run(C_EMPTY, 2'd1, '0, 8'h00);
        check(r_flag == 1'b1, "R8 empty after discard", r_flag, 1);

        // R9 deconfigure
        run(C_SETUP, 2'd1, 16'h0000, 8'h00);
        check(r_rises == 0, "R9 setup base zero no bus", r_rises, 0);
        run(C_FULL, 2'd1, '0, 8'h00);
        check(r_flag == 1'b1 && r_rises == 0, "R9 full after deconfigure", {r_flag, 8'(r_rises)}, 9'h100);

        check(bad_tenure == 0, "R10 access outside grant", bad_tenure, 0);
        check(bad_hold == 0 && stalls > 0, "R13 access held during stall", bad_hold, 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                tests++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule